// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the interrupt causes of a UART into a single prioritised identification byte that the host reads to learn why it was interrupted. Receive errors, receive data, a receive timeout, transmitter emptiness and modem-line changes each set or drive a pending source. Every source is gated by its own enable bit. The highest enabled pending source is encoded into the low nibble of the byte, and an interrupt request line follows the pending bit.

Sticky sources stay pending until the host takes the action that clears them: reading line status, reading modem status, reading the receive buffer, writing the transmit buffer, or reading this byte itself. While the host holds its identification read strobe, the reported byte is frozen. Any cause that arrives during that access shows up after the strobe drops. The FIFO, the serializer and the baud timing sit outside this block and feed it plain status and strobe signals.

Top module: `uart_irq_ident`

## Requirements
- R1: `iir_o[3:0]` holds one of the following codes. With nothing pending it is 0001. The line-error code is 0110, received data is 0100, receive timeout is 1100, transmitter empty is 0010, and modem change is 0000. Bit 0 is 0 whenever a source is reported.
- R2: When several sources are pending, the reported source is chosen in this order: line error, then received data, then receive timeout, then transmitter empty, then modem change.
- R3: Bits 7 and 6 both copy `fifo_en_i`, and bits 5 and 4 are always 0. Bit 3 reads 0 whenever `fifo_en_i` is 0, so a timeout in that mode reports 0100.
- R4: `ier_i` masks the sources before encoding. Bit 0 masks received data and timeout, bit 1 masks transmitter empty, bit 2 masks line error, and bit 3 masks modem change. A sticky source that is set while masked stays latched and is reported once it is enabled.
- R5: `irq_o` is 1 exactly when `iir_o[0]` is 0.
- R6: While `rd_iir_i` is high, `iir_o` keeps the value it had before the strobe rose. Changes made during the access appear on the clock edge at which the strobe is seen low.
- R7: Any bit of `lsr_err_i` sets the line-error source. Bit 0 is overrun, bit 1 is parity, bit 2 is framing and bit 3 is break. A `rd_lsr_i` pulse clears the source.
- R8: The received-data source follows the level of `rx_avail_i`.
- R9: A `rx_tmo_i` pulse latches the timeout source, and a `rd_rbr_i` pulse clears it.
- R10: A rising edge of `thr_empty_i` sets the transmitter-empty source. A `wr_thr_i` pulse clears it. The end of an identification access also clears it, but only when the frozen value showed 0010; an access that showed another source leaves it pending.
- R11: Any bit of `msr_delta_i` sets the modem-change source, and a `rd_msr_i` pulse clears it.
- R12: When a set and a clear of the same sticky source fall in the same cycle, the source ends up pending.
- R13: After reset, `iir_o` is 0x01 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lsr_err_i | input | LSR_W | Receive error pulses: overrun, parity, framing, break |
| rx_avail_i | input | 1 | Receive data present or trigger level reached (level) |
| rx_tmo_i | input | 1 | Receive character timeout pulse |
| thr_empty_i | input | 1 | Transmit holding register empty (level) |
| msr_delta_i | input | MSR_W | Modem-line change pulses |
| fifo_en_i | input | 1 | FIFO mode enable |
| ier_i | input | 4 | Per-source interrupt enables |
| rd_lsr_i | input | 1 | Host reads line status |
| rd_msr_i | input | 1 | Host reads modem status |
| rd_iir_i | input | 1 | Host identification access in progress |
| rd_rbr_i | input | 1 | Host reads receive buffer |
| wr_thr_i | input | 1 | Host writes transmit buffer |
| iir_o | output | 8 | Identification value |
| irq_o | output | 1 | Interrupt request |

## Verification
Two kinds of collision are provoked on purpose, because each can land in a single clock. The first is a new cause arriving while an identification access holds the value frozen. The bench raises a line error in the middle of a multi-cycle access that shows transmitter empty. It then expects the held 0x02 to stay until the strobe drops, the line error to appear next, and transmitter empty to be gone. The second is a set and a clear of the same source in one cycle, for a line error against a status read and for a transmitter-empty edge against a buffer write; both must leave the source pending. A behavioural model running in step with the design also judges several hundred cycles of pseudo-random strobes, where both kinds of overlap occur unplanned.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_NONE    = 4'b0001,
    ID_LINE    = 4'b0110,
    ID_RXDATA  = 4'b0100,
    ID_RXTMO   = 4'b1100,
    ID_TXEMPTY = 4'b0010,
    ID_MODEM   = 4'b0000
  } irq_id_e;

  localparam int IER_W    = 4;
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  localparam logic [7:0] IIR_RESET = 8'h01;

  typedef struct packed {
    logic line;
    logic rxdata;
    logic rxtmo;
    logic txempty;
    logic modem;
  } irq_src_t;

endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch #(
  parameter int SET_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_i,
  input  logic             clr_i,
  output logic             pend_nxt_o
);
  logic pend_q;

  always_comb begin
    if (|set_i)     pend_nxt_o = 1'b1;
    else if (clr_i) pend_nxt_o = 1'b0;
    else            pend_nxt_o = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_nxt_o;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  irq_src_t         src_i,
  input  logic [IER_W-1:0] ier_i,
  input  logic             fifo_en_i,
  output logic [7:0]       iir_o
);
  irq_id_e id;
  logic [3:0] id_bits;

  always_comb begin
    if (src_i.line && ier_i[EN_LINE])         id = ID_LINE;
    else if (src_i.rxdata && ier_i[EN_RX])    id = ID_RXDATA;
    else if (src_i.rxtmo && ier_i[EN_RX])     id = ID_RXTMO;
    else if (src_i.txempty && ier_i[EN_TX])   id = ID_TXEMPTY;
    else if (src_i.modem && ier_i[EN_MODEM])  id = ID_MODEM;
    else                                      id = ID_NONE;
    id_bits = {id[3] & fifo_en_i, id[2:0]};
    iir_o   = {fifo_en_i, fifo_en_i, 2'b00, id_bits};
  end
endmodule

// File: rtl/uart_irq_hold.sv
module uart_irq_hold #(
  parameter int         W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] val_o,
  output logic         done_o
);
  logic rd_q;

  assign done_o = rd_q & ~rd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b0;
      val_o <= RST_VAL;
    end else begin
      rd_q <= rd_i;
      if (!rd_i) val_o <= live_i;
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LSR_W = 4,
  parameter int MSR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LSR_W-1:0] lsr_err_i,
  input  logic             rx_avail_i,
  input  logic             rx_tmo_i,
  input  logic             thr_empty_i,
  input  logic [MSR_W-1:0] msr_delta_i,
  input  logic             fifo_en_i,
  input  logic [3:0]       ier_i,
  input  logic             rd_lsr_i,
  input  logic             rd_msr_i,
  input  logic             rd_iir_i,
  input  logic             rd_rbr_i,
  input  logic             wr_thr_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic     thr_q;
  logic     thr_rise;
  logic     access_done;
  logic     tx_clr;
  logic [7:0] iir_live;
  irq_src_t src;

  always_ff @(posedge clk) begin
    if (rst) thr_q <= 1'b0;
    else     thr_q <= thr_empty_i;
  end
  assign thr_rise = thr_empty_i & ~thr_q;
  assign tx_clr   = wr_thr_i | (access_done & (iir_o[3:0] == ID_TXEMPTY));

  uart_irq_latch #(.SET_W(LSR_W)) u_line (
    .clk(clk), .rst(rst), .set_i(lsr_err_i), .clr_i(rd_lsr_i), .pend_nxt_o(src.line));

  uart_irq_latch #(.SET_W(MSR_W)) u_modem (
    .clk(clk), .rst(rst), .set_i(msr_delta_i), .clr_i(rd_msr_i), .pend_nxt_o(src.modem));

  uart_irq_latch #(.SET_W(1)) u_tmo (
    .clk(clk), .rst(rst), .set_i(rx_tmo_i), .clr_i(rd_rbr_i), .pend_nxt_o(src.rxtmo));

  uart_irq_latch #(.SET_W(1)) u_tx (
    .clk(clk), .rst(rst), .set_i(thr_rise), .clr_i(tx_clr), .pend_nxt_o(src.txempty));

  assign src.rxdata = rx_avail_i;

  uart_irq_prio u_prio (
    .src_i(src), .ier_i(ier_i), .fifo_en_i(fifo_en_i), .iir_o(iir_live));

  uart_irq_hold #(.W(8), .RST_VAL(IIR_RESET)) u_hold (
    .clk(clk), .rst(rst), .rd_i(rd_iir_i), .live_i(iir_live),
    .val_o(iir_o), .done_o(access_done));

  assign irq_o = ~iir_o[0];
endmodule

module uart_irq_ident_chk #(
  parameter int LSR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [LSR_W-1:0] lsr_err_i,
  input logic [3:0]       ier_i,
  input logic             rd_lsr_i,
  input logic             rd_iir_i,
  input logic [7:0]       iir_o
);
  a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
    (iir_o[3:0] == 4'b0001 || iir_o[3:0] == 4'b0110 || iir_o[3:0] == 4'b0100 ||
     iir_o[3:0] == 4'b1100 || iir_o[3:0] == 4'b0010 || iir_o[3:0] == 4'b0000));

  a_r3_upper_bits: assert property (@(posedge clk) disable iff (rst)
    (iir_o[5:4] == 2'b00) && (iir_o[7] == iir_o[6]));

  a_r3_bit3_fifo_only: assert property (@(posedge clk) disable iff (rst)
    !iir_o[6] |-> !iir_o[3]);

  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    rd_iir_i |=> $stable(iir_o));

  a_r7_line_cleared: assert property (@(posedge clk) disable iff (rst)
    (rd_lsr_i && !(|lsr_err_i) && !rd_iir_i) |=> (iir_o[3:0] != 4'b0110));

  a_r12_line_set_wins: assert property (@(posedge clk) disable iff (rst)
    ((|lsr_err_i) && ier_i[2] && !rd_iir_i) |=> (iir_o[3:0] == 4'b0110));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.LSR_W(LSR_W)) u_chk (
  .clk(clk), .rst(rst), .lsr_err_i(lsr_err_i), .ier_i(ier_i),
  .rd_lsr_i(rd_lsr_i), .rd_iir_i(rd_iir_i), .iir_o(iir_o));

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] lsr_err = '0;
  logic       rx_avail = 1'b0, rx_tmo = 1'b0, thr_empty = 1'b0;
  logic [3:0] msr_delta = '0;
  logic       fifo_en = 1'b0;
  logic [3:0] ier = '0;
  logic       rd_lsr = 1'b0, rd_msr = 1'b0, rd_iir = 1'b0, rd_rbr = 1'b0, wr_thr = 1'b0;
  logic [7:0] iir;
  logic       irq;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  string phase = "R1";

  // behavioural reference state
  bit       m_line, m_tmo, m_tx, m_modem, m_thr, m_rd, m_fin, m_txclr;
  bit [7:0] m_iir;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst(rst), .lsr_err_i(lsr_err), .rx_avail_i(rx_avail),
    .rx_tmo_i(rx_tmo), .thr_empty_i(thr_empty), .msr_delta_i(msr_delta),
    .fifo_en_i(fifo_en), .ier_i(ier), .rd_lsr_i(rd_lsr), .rd_msr_i(rd_msr),
    .rd_iir_i(rd_iir), .rd_rbr_i(rd_rbr), .wr_thr_i(wr_thr),
    .iir_o(iir), .irq_o(irq));

  function automatic bit [7:0] ref_code();
    int c;
    if (ier[2] && m_line)        c = 6;
    else if (ier[0] && rx_avail) c = 4;
    else if (ier[0] && m_tmo)    c = fifo_en ? 12 : 4;
    else if (ier[1] && m_tx)     c = 2;
    else if (ier[3] && m_modem)  c = 0;
    else                         c = 1;
    return {fifo_en, fifo_en, 2'b00, c[3:0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_line = 0; m_tmo = 0; m_tx = 0; m_modem = 0; m_thr = 0; m_rd = 0;
      m_iir = 8'h01;
    end else begin
      m_fin   = m_rd && !rd_iir;
      m_txclr = wr_thr || (m_fin && m_iir[3:0] == 4'b0010);
      if (lsr_err != 0) m_line = 1; else if (rd_lsr) m_line = 0;
      if (msr_delta != 0) m_modem = 1; else if (rd_msr) m_modem = 0;
      if (rx_tmo) m_tmo = 1; else if (rd_rbr) m_tmo = 0;
      if (thr_empty && !m_thr) m_tx = 1; else if (m_txclr) m_tx = 0;
      m_thr = thr_empty;
      m_rd  = rd_iir;
      if (!rd_iir) m_iir = ref_code();
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (iir !== m_iir || irq !== ~m_iir[0]) begin
        errors++;
        $display("FAIL %s model: iir=%02h irq=%b expected iir=%02h irq=%b",
                 phase, iir, irq, m_iir, ~m_iir[0]);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] exp);
    checks++;
    if (iir !== exp || irq !== ~exp[0]) begin
      errors++;
      $display("FAIL %s: iir=%02h irq=%b expected iir=%02h irq=%b",
               tag, iir, irq, exp, ~exp[0]);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    chk("R13 reset", 8'h01);
    rst = 1'b0; ier = 4'hF;
    step(); chk("R1 idle", 8'h01);

    phase = "R11";
    msr_delta = 4'b0100; step(); msr_delta = '0;
    chk("R11 modem set / R5 irq", 8'h00);
    phase = "R2";
    thr_empty = 1'b1; step(); chk("R2 tx over modem", 8'h02);
    phase = "R8";
    rx_avail = 1'b1; step(); chk("R8 data over tx", 8'h04);
    phase = "R7";
    lsr_err = 4'b0010; step(); lsr_err = '0; chk("R7 parity set", 8'h06);
    rd_lsr = 1'b1; step(); rd_lsr = 1'b0; chk("R7 lsr read clears", 8'h04);
    phase = "R8";
    rx_avail = 1'b0; step(); chk("R8 data level drops", 8'h02);

    phase = "R6";
    rd_iir = 1'b1; step(); chk("R6 held at start", 8'h02);
    lsr_err = 4'b1000; step(); lsr_err = '0; chk("R6 held over new cause", 8'h02);
    step(); chk("R6 still held", 8'h02);
    rd_iir = 1'b0; step(); chk("R6 released shows line", 8'h06);
    phase = "R10";
    rd_lsr = 1'b1; step(); rd_lsr = 1'b0; chk("R10 tx cleared by read", 8'h00);
    phase = "R11";
    rd_msr = 1'b1; step(); rd_msr = 1'b0; chk("R11 msr read clears", 8'h01);

    phase = "R10";
    thr_empty = 1'b0; step();
    thr_empty = 1'b1; step(); chk("R10 tx edge", 8'h02);
    lsr_err = 4'b0001; step(); lsr_err = '0; chk("R7 overrun", 8'h06);
    rd_iir = 1'b1; step(); rd_iir = 1'b0; step(); chk("R10 read of line keeps line", 8'h06);
    rd_lsr = 1'b1; step(); rd_lsr = 1'b0; chk("R10 tx kept when not shown", 8'h02);
    wr_thr = 1'b1; step(); wr_thr = 1'b0; chk("R10 write clears tx", 8'h01);

    phase = "R3";
    fifo_en = 1'b1; step(); chk("R3 fifo bits", 8'hC1);
    phase = "R9";
    rx_tmo = 1'b1; step(); rx_tmo = 1'b0; chk("R9 timeout", 8'hCC);
    phase = "R2";
    rx_avail = 1'b1; step(); chk("R2 data over timeout", 8'hC4);
    rx_avail = 1'b0; step(); chk("R2 timeout returns", 8'hCC);
    phase = "R3";
    fifo_en = 1'b0; step(); chk("R3 bit3 forced low", 8'h04);
    fifo_en = 1'b1; phase = "R9";
    rd_rbr = 1'b1; step(); rd_rbr = 1'b0; chk("R9 rbr read clears", 8'hC1);

    phase = "R4";
    ier = 4'h0; lsr_err = 4'b0100; step(); lsr_err = '0; chk("R4 masked", 8'hC1);
    ier = 4'b0100; step(); chk("R4 latched shows", 8'hC6);
    phase = "R12";
    rd_lsr = 1'b1; lsr_err = 4'b0001; step(); rd_lsr = 1'b0; lsr_err = '0;
    chk("R12 line set wins", 8'hC6);
    rd_lsr = 1'b1; step(); rd_lsr = 1'b0; chk("R7 cleared", 8'hC1);
    ier = 4'hF; thr_empty = 1'b0; step();
    thr_empty = 1'b1; wr_thr = 1'b1; step(); wr_thr = 1'b0;
    chk("R12 tx set wins", 8'hC2);

    phase = "R6";
    for (int i = 0; i < 600; i++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      lsr_err   = (seed[3:0] == 4'h0) ? seed[7:4] : 4'h0;
      msr_delta = (seed[10:8] == 3'h0) ? seed[14:11] : 4'h0;
      rx_avail  = seed[15] & seed[16];
      rx_tmo    = (seed[19:17] == 3'h0);
      thr_empty = seed[20] | seed[21];
      fifo_en   = (i > 300);
      ier       = seed[25:22] | 4'b0110;
      rd_lsr    = (seed[27:26] == 2'b00);
      rd_msr    = (seed[29:28] == 2'b00);
      rd_rbr    = (seed[31:30] == 2'b00);
      wr_thr    = seed[2] & seed[9] & seed[18];
      if (seed[12:11] == 2'b00) rd_iir = ~rd_iir;
      step();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule